// File: doc/BRIEF.md
# Serial Transmit Path with FIFO Interrupts

This block is the transmit half of an asynchronous serial port. Words written through a register-style write port are queued in a small FIFO, then shifted out one character at a time on `txd`. The character format can be set: five to eight data bits, no parity, odd parity or even parity, and one or two stop bits. The bit rate comes from outside as a one-cycle strobe, `bit_tick`. Each strobe ends the bit now on the line.

Four interrupt sources feed a status vector. Each source has its own enable and its own clear. One source reports that the FIFO level is below a programmable threshold. One reports that a write was lost to overflow. One reports that the whole path is idle, meaning the FIFO is empty and the shifter is not busy. The last reports that the active-low clear-to-send input changed after synchronization.

The transmitter enable and the FIFO clear are separate controls. Dropping the enable stops the FIFO from draining, and clearing the FIFO does not disturb a character that is already being shifted.

Top module: `serial_tx_fifo_irq`

## Requirements
- R1: After reset, `txd` is 1, `wr_ready` is 1, `tx_busy` is 0 and `fifo_level` is 0. With `tx_trig` at 0, `irq_sts` reads 4'b0100.
- R2: Each character on `txd` is sent in this order: a 0 start bit, then the data bits LSB first, then the parity bit if enabled, then one stop bit (two if `cfg_two_stop`=1). The stop bits are 1. The number of data bits is 5+`cfg_word_len`. A character starts on the cycle after it is taken from the FIFO, and each `bit_tick` moves to the next bit. Between characters the line is 1.
- R3: With `cfg_par_en`=1, the parity bit makes the count of ones across data plus parity even when `cfg_par_even`=1, and odd when `cfg_par_even`=0.
- R4: The FIFO holds 16 entries and stores bits 7:0 of `wr_data`. `wr_ready` is 1 exactly when fewer than 16 entries are stored, and an accepted write raises `fifo_level` by one in the next cycle.
- R5: A write while the FIFO is full is dropped and sets `irq_sts[1]`. That bit holds until `sts_clr` or `irq_clr[1]` is high. If a new loss and a clear fall in the same cycle, the bit stays set.
- R6: `tx_busy` is 1 while the FIFO holds any entry or a character is being shifted.
- R7: `irq_sts[0]` is 1 while `fifo_level` is strictly below `tx_trig`.
- R8: `irq_sts[2]` is 1 exactly when the FIFO is empty and no character is being shifted.
- R9: `cts_n` passes through two synchronizer flops. Each change of the synchronized value sets `irq_sts[3]`, which holds until `irq_clr[3]` is high.
- R10: `fifo_clr` empties the FIFO in the next cycle and beats a write in the same cycle; that write is neither stored nor counted as lost. A character already being shifted is completed.
- R11: While `tx_enable`=0 no new character leaves the FIFO; a character already started is completed.
- R12: `irq` is the OR of `irq_sts & irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle bit-rate strobe |
| tx_enable | input | 1 | Allows the FIFO to drain into the shifter |
| cfg_word_len | input | 2 | Data bits minus five |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_two_stop | input | 1 | Two stop bits |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WORD_W | Write word; bits 7:0 are used |
| fifo_clr | input | 1 | Empties the FIFO |
| sts_clr | input | 1 | Clears the overflow-loss flag |
| tx_trig | input | CNT_W | FIFO level threshold |
| irq_en | input | 4 | Per-source interrupt enables |
| irq_clr | input | 4 | Clears for sticky sources (bits 1 and 3) |
| cts_n | input | 1 | Asynchronous active-low clear-to-send |
| txd | output | 1 | Serial line |
| wr_ready | output | 1 | FIFO can take a word |
| tx_busy | output | 1 | FIFO or shifter occupied |
| fifo_level | output | CNT_W | Entries stored |
| irq_sts | output | 4 | {cts change, idle, overflow loss, level} |
| irq | output | 1 | Combined interrupt request |

## Verification
Several properties are checked on every cycle. A write refused while the FIFO is full must leave the loss flag set on the next cycle. An accepted write must raise the level by one. A FIFO clear must leave the level at zero. A disabled transmitter must never start a character, and every character must begin with a low start bit. A raised CTS-change flag must hold until it is cleared. Other behaviours can only be shown by the bench scenarios, which compare each cycle against a queue-based model: the full bit order of each format and its parity value, the enable being dropped partway through a character, and the threshold and enable combinations that reach `irq`.

// File: rtl/stx_pkg.sv
package stx_pkg;
   localparam int DATA_BITS = 8;
   localparam int FRAME_W   = DATA_BITS + 4;
   localparam int IRQ_N     = 4;
   localparam int IRQ_LVL   = 0;
   localparam int IRQ_LOST  = 1;
   localparam int IRQ_IDLE  = 2;
   localparam int IRQ_CTS   = 3;

   typedef struct packed {
      logic [1:0] word_len;
      logic       par_en;
      logic       par_even;
      logic       two_stop;
   } stx_fmt_t;
endpackage

// File: rtl/stx_fifo.sv
module stx_fifo #(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic             pop,
   input  logic [DW-1:0]    din,
   output logic [DW-1:0]    dout,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);
   generate
      if ((1 << PTR_W) != DEPTH || DEPTH < 2) begin : g_bad_depth
         $error("stx_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [DW-1:0]    mem_q [DEPTH];
   logic [PTR_W-1:0] wp_q, rp_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (push && !clr) mem_q[wp_q] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wp_q <= wp_q + PTR_W'(1);
         if (pop)  rp_q <= rp_q + PTR_W'(1);
         cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
      end
   end

   assign dout  = mem_q[rp_q];
   assign count = cnt_q;
   assign full  = (cnt_q == CNT_W'(DEPTH));
   assign empty = (cnt_q == '0);
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
   import stx_pkg::*;
#(
   localparam int LEN_W = $clog2(FRAME_W + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [DATA_BITS-1:0] din,
   input  stx_fmt_t             fmt,
   input  logic                 bit_tick,
   output logic                 busy,
   output logic                 txd
);
   logic [FRAME_W-1:0]   frame_d, frame_q;
   logic [LEN_W-1:0]     len_d, left_q;
   logic [DATA_BITS-1:0] masked;
   logic                 par_bit;
   logic                 busy_q;
   int                   nbits;

   always_comb begin
      nbits  = 5 + int'(fmt.word_len);
      masked = '0;
      for (int i = 0; i < DATA_BITS; i++) begin
         if (i < nbits) masked[i] = din[i];
      end
      par_bit = (^masked) ^ ~fmt.par_even;
      frame_d = '1;
      frame_d[0] = 1'b0;
      for (int i = 0; i < DATA_BITS; i++) begin
         if (i < nbits) frame_d[i+1] = din[i];
      end
      if (fmt.par_en) frame_d[nbits+1] = par_bit;
      len_d = LEN_W'(2 + nbits + int'(fmt.par_en) + int'(fmt.two_stop));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_q <= '1;
         left_q  <= '0;
         busy_q  <= 1'b0;
      end else if (load) begin
         frame_q <= frame_d;
         left_q  <= len_d;
         busy_q  <= 1'b1;
      end else if (busy_q && bit_tick) begin
         frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
         left_q  <= left_q - LEN_W'(1);
         if (left_q == LEN_W'(1)) busy_q <= 1'b0;
      end
   end

   assign busy = busy_q;
   assign txd  = busy_q ? frame_q[0] : 1'b1;
endmodule

// File: rtl/stx_cts_sync.sv
module stx_cts_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cts_n,
   output logic changed
);
   logic [STAGES-1:0] sync_q;
   logic              last_q;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("stx_cts_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= cts_n;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[STAGES-2:0], cts_n};
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= 1'b1;
      else        last_q <= sync_q[STAGES-1];
   end

   assign changed = sync_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/serial_tx_fifo_irq.sv
module serial_tx_fifo_irq
   import stx_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int WORD_W     = 32,
   parameter int CTS_SYNC   = 2,
   localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              tx_enable,
   input  logic [1:0]        cfg_word_len,
   input  logic              cfg_par_en,
   input  logic              cfg_par_even,
   input  logic              cfg_two_stop,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              fifo_clr,
   input  logic              sts_clr,
   input  logic [CNT_W-1:0]  tx_trig,
   input  logic [IRQ_N-1:0]  irq_en,
   input  logic [IRQ_N-1:0]  irq_clr,
   input  logic              cts_n,
   output logic              txd,
   output logic              wr_ready,
   output logic              tx_busy,
   output logic [CNT_W-1:0]  fifo_level,
   output logic [IRQ_N-1:0]  irq_sts,
   output logic              irq
);
   generate
      if (WORD_W < DATA_BITS) begin : g_bad_word
         $error("serial_tx_fifo_irq: WORD_W must be at least 8");
      end
      if (WORD_W > DATA_BITS) begin : g_wide
         logic unused_hi;
         assign unused_hi = ^wr_data[WORD_W-1:DATA_BITS];
      end
   endgenerate

   logic unused_clr;
   assign unused_clr = irq_clr[IRQ_LVL] ^ irq_clr[IRQ_IDLE];

   stx_fmt_t             fmt;
   logic                 fifo_full, fifo_empty, fifo_pop, fifo_push, lost;
   logic [DATA_BITS-1:0] head;
   logic                 sh_busy, cts_chg;
   logic                 lost_q, cts_q;

   assign fmt       = '{word_len: cfg_word_len, par_en: cfg_par_en,
                        par_even: cfg_par_even, two_stop: cfg_two_stop};
   assign fifo_pop  = tx_enable && !sh_busy && !fifo_empty;
   assign fifo_push = wr_en && !fifo_full && !fifo_clr;
   assign lost      = wr_en && fifo_full && !fifo_clr;

   stx_fifo #(.DEPTH(FIFO_DEPTH), .DW(DATA_BITS)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (fifo_clr),
      .push  (fifo_push),
      .pop   (fifo_pop),
      .din   (wr_data[DATA_BITS-1:0]),
      .dout  (head),
      .count (fifo_level),
      .full  (fifo_full),
      .empty (fifo_empty)
   );

   stx_shifter u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (fifo_pop),
      .din      (head),
      .fmt      (fmt),
      .bit_tick (bit_tick),
      .busy     (sh_busy),
      .txd      (txd)
   );

   stx_cts_sync #(.STAGES(CTS_SYNC)) u_cts (
      .clk     (clk),
      .rst_n   (rst_n),
      .cts_n   (cts_n),
      .changed (cts_chg)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lost_q <= 1'b0;
         cts_q  <= 1'b0;
      end else begin
         if (lost)                                lost_q <= 1'b1;
         else if (sts_clr || irq_clr[IRQ_LOST])   lost_q <= 1'b0;
         if (cts_chg)                             cts_q  <= 1'b1;
         else if (irq_clr[IRQ_CTS])               cts_q  <= 1'b0;
      end
   end

   assign wr_ready = !fifo_full;
   assign tx_busy  = sh_busy || !fifo_empty;

   always_comb begin
      irq_sts           = '0;
      irq_sts[IRQ_LVL]  = fifo_level < tx_trig;
      irq_sts[IRQ_LOST] = lost_q;
      irq_sts[IRQ_IDLE] = !tx_busy;
      irq_sts[IRQ_CTS]  = cts_q;
   end

   assign irq = |(irq_sts & irq_en);
endmodule

// File: rtl/stx_chk.sv
module stx_chk #(
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_enable,
   input logic             wr_en,
   input logic             fifo_clr,
   input logic             wr_ready,
   input logic             txd,
   input logic [CNT_W-1:0] fifo_level,
   input logic [3:0]       irq_sts,
   input logic [3:0]       irq_clr,
   input logic             sh_busy,
   input logic             fifo_pop
);
   assert_lost_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_ready && !fifo_clr) |=> irq_sts[1]);

   assert_push_counts_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ready && !fifo_clr && !fifo_pop) |=>
      (fifo_level == $past(fifo_level) + CNT_W'(1)));

   assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clr |=> (fifo_level == '0));

   assert_no_start_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_enable && !sh_busy) |=> !sh_busy);

   assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sh_busy) |-> !txd);

   assert_cts_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_sts[3] && !irq_clr[3]) |=> irq_sts[3]);
endmodule

bind serial_tx_fifo_irq stx_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_enable  (tx_enable),
   .wr_en      (wr_en),
   .fifo_clr   (fifo_clr),
   .wr_ready   (wr_ready),
   .txd        (txd),
   .fifo_level (fifo_level),
   .irq_sts    (irq_sts),
   .irq_clr    (irq_clr),
   .sh_busy    (sh_busy),
   .fifo_pop   (fifo_pop)
);

// File: tb/serial_tx_fifo_irq_tb.sv
module serial_tx_fifo_irq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 16;
   localparam int CW         = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_tick = 1'b0;
   logic tx_en = 1'b0;
   logic [1:0] wl = 2'd3;
   logic pe = 1'b0, pev = 1'b0, ts = 1'b0;
   logic wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic fclr = 1'b0, sclr = 1'b0;
   logic [CW-1:0] trig = '0;
   logic [3:0] ien = '0, iclr = '0;
   logic cts_n = 1'b1;

   logic txd, wr_ready, tx_busy, irq;
   logic [CW-1:0] fifo_level;
   logic [3:0] irq_sts;

   int checks = 0;
   int fails = 0;
   int tcnt = 0;

   serial_tx_fifo_irq u_dut (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_enable(tx_en),
      .cfg_word_len(wl), .cfg_par_en(pe), .cfg_par_even(pev), .cfg_two_stop(ts),
      .wr_en(wr_en), .wr_data(wr_data), .fifo_clr(fclr), .sts_clr(sclr),
      .tx_trig(trig), .irq_en(ien), .irq_clr(iclr), .cts_n(cts_n),
      .txd(txd), .wr_ready(wr_ready), .tx_busy(tx_busy), .fifo_level(fifo_level),
      .irq_sts(irq_sts), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      #1;
      tcnt = (tcnt + 1) % 4;
      bit_tick = (tcnt == 0);
   end

   // behavioural reference model
   logic [7:0] mq[$];
   bit mb[$];
   bit mbusy = 0, mlost = 0, mcts = 0, s1 = 1, s2 = 1, s3 = 1;

   task automatic build(input logic [7:0] d);
      int n;
      bit p;
      n = 5 + int'(wl);
      p = 0;
      mb.delete();
      mb.push_back(1'b0);
      for (int i = 0; i < n; i++) begin
         mb.push_back(d[i]);
         p = p ^ d[i];
      end
      if (pe) mb.push_back(pev ? p : ~p);
      mb.push_back(1'b1);
      if (ts) mb.push_back(1'b1);
   endtask

   always @(posedge clk) begin
      int osz;
      bit ld, chg, lst;
      if (!rst_n) begin
         mq.delete(); mb.delete();
         mbusy = 0; mlost = 0; mcts = 0; s1 = 1; s2 = 1; s3 = 1;
      end else begin
         osz = mq.size();
         ld  = !mbusy && tx_en && (osz > 0);
         chg = s2 ^ s3;
         lst = 0;
         if (mbusy && bit_tick) begin
            void'(mb.pop_front());
            if (mb.size() == 0) mbusy = 0;
         end
         if (ld) begin
            build(mq.pop_front());
            mbusy = 1;
         end
         if (fclr) mq.delete();
         else if (wr_en) begin
            if (osz < DEPTH) mq.push_back(wr_data[7:0]);
            else lst = 1;
         end
         if (lst) mlost = 1;
         else if (sclr || iclr[1]) mlost = 0;
         if (chg) mcts = 1;
         else if (iclr[3]) mcts = 0;
         s3 = s2; s2 = s1; s1 = cts_n;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      bit ebusy, etxd;
      logic [3:0] ests;
      if (rst_n) begin
         ebusy = mbusy || (mq.size() > 0);
         etxd  = mbusy ? mb[0] : 1'b1;
         ests  = {mcts, ~ebusy, mlost, (int'(mq.size()) < int'(trig))};
         chk(txd == etxd, "R2/R3 txd", int'(txd), int'(etxd));
         chk(wr_ready == (mq.size() < DEPTH), "R4 wr_ready", int'(wr_ready), int'(mq.size() < DEPTH));
         chk(int'(fifo_level) == mq.size(), "R4/R10 fifo_level", int'(fifo_level), mq.size());
         chk(tx_busy == ebusy, "R6 tx_busy", int'(tx_busy), int'(ebusy));
         chk(irq_sts[0] == ests[0], "R7 level", int'(irq_sts[0]), int'(ests[0]));
         chk(irq_sts[1] == ests[1], "R5 lost", int'(irq_sts[1]), int'(ests[1]));
         chk(irq_sts[2] == ests[2], "R8 idle", int'(irq_sts[2]), int'(ests[2]));
         chk(irq_sts[3] == ests[3], "R9 cts", int'(irq_sts[3]), int'(ests[3]));
         chk(irq == |(ests & ien), "R12 irq", int'(irq), int'(|(ests & ien)));
      end
   end

   task automatic cyc(input int n);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   task automatic wr(input logic [31:0] d);
      wr_en = 1; wr_data = d;
      cyc(1);
      wr_en = 0;
   endtask

   task automatic wait_idle();
      while (tx_busy) cyc(1);
      cyc(2);
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      cyc(3);
      rst_n = 1;
      cyc(1);
      // R1 reset state
      chk(txd == 1'b1, "R1 txd", int'(txd), 1);
      chk(wr_ready == 1'b1, "R1 wr_ready", int'(wr_ready), 1);
      chk(tx_busy == 1'b0, "R1 tx_busy", int'(tx_busy), 0);
      chk(fifo_level == '0, "R1 fifo_level", int'(fifo_level), 0);
      chk(irq_sts == 4'b0100, "R1 irq_sts", int'(irq_sts), 4);

      tx_en = 1; ien = 4'hF;
      wr(32'hDEAD_0055); wr(32'h1234_00A3); wr(32'h0000_00FF);
      wait_idle();
      wl = 2; pe = 1; pev = 1;
      wr(32'h0000_0013); wr(32'h0000_0047);
      wait_idle();
      wl = 0; pe = 1; pev = 0; ts = 1;
      wr(32'h0000_0015); wr(32'h0000_000A);
      wait_idle();
      wl = 1; pe = 0; ts = 1;
      wr(32'h0000_002C);
      wait_idle();
      wl = 3; ts = 0;

      // R7 threshold
      trig = 5'd8; ien = 4'b0001;
      tx_en = 0;
      for (int i = 0; i < 10; i++) wr(32'h100 + i);
      chk(irq_sts[0] == 1'b0, "R7 above threshold", int'(irq_sts[0]), 0);
      tx_en = 1;
      wait_idle();
      trig = 5'd0; ien = 4'b0010;

      // R5 loss
      tx_en = 0;
      for (int i = 0; i < 17; i++) wr(32'h40 + i);
      chk(irq_sts[1] == 1'b1, "R5 lost set", int'(irq_sts[1]), 1);
      chk(fifo_level == 5'd16, "R4 full level", int'(fifo_level), 16);
      chk(wr_ready == 1'b0, "R4 full ready", int'(wr_ready), 0);
      sclr = 1; cyc(1); sclr = 0;
      chk(irq_sts[1] == 1'b0, "R5 sts_clr", int'(irq_sts[1]), 1'b0);
      wr(32'h99);
      iclr = 4'b0010; cyc(1); iclr = 0;
      chk(irq_sts[1] == 1'b0, "R5 irq_clr", int'(irq_sts[1]), 0);

      // R10 clear beats write
      fclr = 1; wr_en = 1; wr_data = 32'h77; cyc(1); fclr = 0; wr_en = 0;
      chk(fifo_level == '0, "R10 cleared", int'(fifo_level), 0);
      chk(irq_sts[1] == 1'b0, "R10 no loss", int'(irq_sts[1]), 0);

      // R11 disabled hold
      wr(32'h3C);
      cyc(40);
      chk(txd == 1'b1, "R11 line idle", int'(txd), 1);
      chk(fifo_level == 5'd1, "R11 held", int'(fifo_level), 1);
      fclr = 1; cyc(1); fclr = 0;
      wr(32'hC3); wr(32'h5A);
      tx_en = 1; cyc(5);
      tx_en = 0; cyc(100);
      chk(fifo_level == 5'd1, "R11 mid-frame stop", int'(fifo_level), 1);
      chk(txd == 1'b1, "R11 frame done", int'(txd), 1);
      tx_en = 1; cyc(5);
      fclr = 1; cyc(1); fclr = 0;
      ien = 4'b0100;
      wait_idle();

      // R9 cts change
      ien = 4'b1000;
      cts_n = 0; cyc(5);
      chk(irq_sts[3] == 1'b1, "R9 cts fall", int'(irq_sts[3]), 1);
      iclr = 4'b1000; cyc(1); iclr = 0;
      chk(irq_sts[3] == 1'b0, "R9 cts clr", int'(irq_sts[3]), 0);
      cts_n = 1; cyc(5);
      chk(irq_sts[3] == 1'b1, "R9 cts rise", int'(irq_sts[3]), 1);
      chk(irq == 1'b1, "R12 irq on", int'(irq), 1);
      iclr = 4'b1000; cyc(2); iclr = 0;
      cyc(5);
      finish_run();
   end
endmodule